// File: doc/BRIEF.md
# Ultraviolet-Erasable Byte Memory Mode Model

This block is a synthesizable behavioural model of a byte-wide, ultraviolet-erasable programmable read-only memory. It is meant to stand in for such a part inside a larger simulation or emulation. It decodes an active-low chip select, an active-low output enable, a flag saying that programming voltage is present on the output-enable pin, a flag saying that an identify voltage is present on address line 9, and the address. From these it selects one of several modes: standby, output disable, read or program verify, program, program inhibit and device identify. The storage array starts fully erased (all ones), and programming can only clear bits.

Programming takes place once for each falling edge of chip select, sampled on the clock, while programming voltage is present. Each program cycle stores the bitwise AND of the old byte and the input byte. In identify mode the block returns two fixed codes, and bit 7 of each code makes the parity of the byte odd. An erase request, and also reset, starts a sweep that writes all ones to every address, one address per cycle. A busy flag stays high until the sweep ends. The data bus is modelled as a data-out vector with a separate drive enable. The default depth is 2048 bytes. Setting `ADDR_W` to 16 gives the full 64K by 8 array.

Top module: `eprom_model`

## Requirements
- R1: Reset starts an erase sweep. `eraseBusy` reads 1 during and right after reset, and `dataOe` reads 0. Once the sweep ends, every byte reads 8'hFF.
- R2: A program cycle at address A with input byte D leaves A holding the old byte AND D. A later read at A returns that value.
- R3: Programming happens only on the clock edge at which `ceN` is first seen low while `vppOn` is 1. Holding `ceN` low with `vppOn` at 1 does not write again, even if `dataIn` changes.
- R4: With `ceN` high, `dataOe` is 0 whatever `oeN` is. With `vppOn` at 1 and `ceN` high, programming is inhibited and the addressed byte is left unchanged.
- R5: With `ceN` low, `oeN` high and `vppOn` at 0 (output disable), `dataOe` is 0.
- R6: With `ceN` low, `oeN` low, `vppOn` at 0 and `idHv` at 0 (read or verify), `dataOe` is 1 and `dataOut` is the stored byte at `addr`. While `vppOn` is 1, `dataOe` is 0.
- R7: With `ceN` low, `oeN` low, `vppOn` at 0, `idHv` at 1 and the qualifying address, `dataOut` is 8'hC2 when `addr[0]` is 0 and 8'h91 when `addr[0]` is 1.
- R8: Identify needs every address bit other than bit 0 and bit 9 to be zero. Bit 9 is ignored. With any other bit set, the block returns array data instead.
- R9: Each identify byte has an odd number of ones across all 8 bits.
- R10: While `eraseBusy` is 1, `dataOe` is 0 and no program cycle takes place.
- R11: An `eraseReq` pulse while idle raises `eraseBusy` at the next edge. `eraseBusy` then stays high for exactly 2^ADDR_W sampled cycles, after which every byte reads 8'hFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Model clock |
| rstN | input | 1 | Asynchronous active-low reset; starts an erase sweep |
| ceN | input | 1 | Active-low chip select; its falling edge triggers programming |
| oeN | input | 1 | Active-low output enable |
| vppOn | input | 1 | Programming voltage present on the output-enable pin |
| idHv | input | 1 | Identify voltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| dataIn | input | 8 | Byte to program |
| eraseReq | input | 1 | Request a full-array erase sweep |
| dataOut | output | 8 | Byte driven on the bus |
| dataOe | output | 1 | Bus drive enable (0 = high impedance) |
| eraseBusy | output | 1 | Erase sweep in progress |

## Verification
Mode decoding and the read path are combinational. `dataOe` and `dataOut` therefore follow the pins within the same cycle. A program cycle changes the array at the first rising edge after `ceN` falls. The bench drives the pins at the falling clock edge and samples 1 ns after the following rising edge, so both kinds of result are checked at that single point. The erase flag turns on one edge after the request. The bench counts the rising edges during which it samples `eraseBusy` high and expects the count to equal the array depth exactly.

// File: rtl/eprom_pkg.sv
package eprom_pkg;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DISABLE,
    MODE_READ,
    MODE_IDENT,
    MODE_PROGRAM,
    MODE_INHIBIT,
    MODE_ERASE
  } epromMode_t;

  typedef struct packed {
    logic progWr;
    logic eraseWr;
    logic outEn;
    logic identSel;
    logic identByte;
  } epromStrobe_t;

endpackage

// File: rtl/eprom_ctrl.sv
module eprom_ctrl
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int ID_BIT = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              vppOn,
  input  logic              idHv,
  input  logic [ADDR_W-1:0] addr,
  input  logic              eraseReq,
  output epromStrobe_t      strobe,
  output logic [ADDR_W-1:0] erasePtr,
  output logic              eraseBusy
);

  localparam logic [ADDR_W-1:0] ID_KEEP  = (ADDR_W'(1) << ID_BIT) | ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ID_CLEAR = ~ID_KEEP;
  localparam logic [ADDR_W-1:0] LAST_PTR = '1;

  logic       ceNq;
  logic       idAddrOk;
  logic       ceFall;
  epromMode_t mode;

  assign idAddrOk = ((addr & ID_CLEAR) == '0);
  assign ceFall   = ceNq && !ceN;

  always_comb begin
    if (eraseBusy)              mode = MODE_ERASE;
    else if (vppOn && ceN)      mode = MODE_INHIBIT;
    else if (ceN)               mode = MODE_STANDBY;
    else if (vppOn)             mode = MODE_PROGRAM;
    else if (oeN)               mode = MODE_DISABLE;
    else if (idHv && idAddrOk)  mode = MODE_IDENT;
    else                        mode = MODE_READ;
  end

  always_comb begin
    strobe           = '0;
    strobe.eraseWr   = eraseBusy;
    strobe.progWr    = (mode == MODE_PROGRAM) && ceFall;
    strobe.outEn     = (mode == MODE_READ) || (mode == MODE_IDENT);
    strobe.identSel  = (mode == MODE_IDENT);
    strobe.identByte = addr[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceNq      <= 1'b1;
      eraseBusy <= 1'b1;
      erasePtr  <= '0;
    end else begin
      ceNq <= ceN;
      if (eraseBusy) begin
        erasePtr <= erasePtr + 1'b1;
        if (erasePtr == LAST_PTR) eraseBusy <= 1'b0;
      end else if (eraseReq) begin
        eraseBusy <= 1'b1;
        erasePtr  <= '0;
      end
    end
  end

  AST_PROG_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.progWr |=> !strobe.progWr); // R3
  AST_NO_PROG_IN_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |-> !strobe.progWr); // R10

endmodule

// File: rtl/eprom_datapath.sv
module eprom_datapath
  import eprom_pkg::*;
#(
  parameter int          ADDR_W   = 11,
  parameter int          DATA_W   = 8,
  parameter logic [7:0]  MFR_CODE = 8'hC2,
  parameter logic [7:0]  DEV_CODE = 8'h91
) (
  input  logic              clk,
  input  logic              rstN,
  input  epromStrobe_t      strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] erasePtr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] codeByte;

  always_ff @(posedge clk) begin
    if (strobe.eraseWr)     mem[erasePtr] <= '1;
    else if (strobe.progWr) mem[addr]     <= mem[addr] & dataIn;
  end

  assign codeByte = strobe.identByte ? DATA_W'(DEV_CODE) : DATA_W'(MFR_CODE);

  always_comb begin
    if (!strobe.outEn)        dataOut = '0;
    else if (strobe.identSel) dataOut = codeByte;
    else                      dataOut = mem[addr];
  end

  assign dataOe = strobe.outEn;

  AST_ID_ODD_PARITY: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.outEn && strobe.identSel) |-> (^dataOut)); // R9

endmodule

// File: rtl/eprom_model.sv
module eprom_model
  import eprom_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              vppOn,
  input  logic              idHv,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        dataIn,
  input  logic              eraseReq,
  output logic [7:0]        dataOut,
  output logic              dataOe,
  output logic              eraseBusy
);

  epromStrobe_t      strobe;
  logic [ADDR_W-1:0] erasePtr;

  eprom_ctrl #(.ADDR_W(ADDR_W), .ID_BIT(9)) ctrl_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .vppOn(vppOn),
    .idHv(idHv), .addr(addr), .eraseReq(eraseReq), .strobe(strobe),
    .erasePtr(erasePtr), .eraseBusy(eraseBusy)
  );

  eprom_datapath #(.ADDR_W(ADDR_W), .DATA_W(8)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addr(addr),
    .erasePtr(erasePtr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    ceN |-> !dataOe); // R4
  AST_ERASE_HIZ: assert property (@(posedge clk) disable iff (!rstN)
    eraseBusy |-> !dataOe); // R10
  AST_VPP_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    vppOn |-> !dataOe); // R6

endmodule

// File: tb/eprom_model_tb.sv
module eprom_model_tb_top;

  localparam int ADDR_W = 11;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int NVEC   = 16;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              ceN = 1'b1, oeN = 1'b1, vppOn = 1'b0, idHv = 1'b0, eraseReq = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        dataIn = '0;
  logic [7:0]        dataOut;
  logic              dataOe, eraseBusy;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  eprom_model #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .vppOn(vppOn), .idHv(idHv),
    .addr(addr), .dataIn(dataIn), .eraseReq(eraseReq),
    .dataOut(dataOut), .dataOe(dataOe), .eraseBusy(eraseBusy)
  );

  // row: tag, ceN, oeN, vppOn, idHv, addr[15:0], dataIn, expOe, expData
  function automatic logic [47:0] mk(input logic [7:0] tag, input logic c, input logic o,
                                     input logic v, input logic h, input logic [15:0] a,
                                     input logic [7:0] d, input logic eo, input logic [7:0] ed);
    return {tag, c, o, v, h, a, d, eo, ed, 3'b000};
  endfunction

  localparam logic [47:0] TBL [NVEC] = '{
    mk(8'd1,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0005, 8'h00, 1'b1, 8'hFF), // R1 erased read
    mk(8'd4,  1'b1, 1'b1, 1'b1, 1'b0, 16'h0005, 8'hA5, 1'b0, 8'h00), // R4 vpp, ce high
    mk(8'd2,  1'b0, 1'b1, 1'b1, 1'b0, 16'h0005, 8'hA5, 1'b0, 8'h00), // R2 program A5
    mk(8'd6,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0005, 8'h00, 1'b1, 8'hA5), // R6 verify
    mk(8'd4,  1'b1, 1'b0, 1'b0, 1'b0, 16'h0005, 8'h00, 1'b0, 8'h00), // R4 ce high, oe low
    mk(8'd2,  1'b0, 1'b0, 1'b1, 1'b0, 16'h0005, 8'h3C, 1'b0, 8'h00), // R2 program 3C
    mk(8'd3,  1'b0, 1'b0, 1'b1, 1'b0, 16'h0005, 8'h00, 1'b0, 8'h00), // R3 held low
    mk(8'd3,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0005, 8'h00, 1'b1, 8'h24), // R3 / R2 A5&3C
    mk(8'd5,  1'b0, 1'b1, 1'b0, 1'b0, 16'h0005, 8'h00, 1'b0, 8'h00), // R5 disable
    mk(8'd4,  1'b1, 1'b0, 1'b1, 1'b0, 16'h0007, 8'h00, 1'b0, 8'h00), // R4 inhibit
    mk(8'd4,  1'b0, 1'b0, 1'b0, 1'b0, 16'h0007, 8'h00, 1'b1, 8'hFF), // R4 inhibited byte intact
    mk(8'd7,  1'b0, 1'b0, 1'b0, 1'b1, 16'h0000, 8'h00, 1'b1, 8'hC2), // R7 maker code
    mk(8'd7,  1'b0, 1'b0, 1'b0, 1'b1, 16'h0001, 8'h00, 1'b1, 8'h91), // R7 device code
    mk(8'd8,  1'b0, 1'b0, 1'b0, 1'b1, 16'h0201, 8'h00, 1'b1, 8'h91), // R8 bit 9 ignored
    mk(8'd8,  1'b0, 1'b0, 1'b0, 1'b1, 16'h0005, 8'h00, 1'b1, 8'h24), // R8 bit 2 set -> array
    mk(8'd8,  1'b0, 1'b0, 1'b0, 1'b1, 16'h0400, 8'h00, 1'b1, 8'hFF)  // R8 bit 10 set -> array
  };

  task automatic check(input string tag, input logic expOe, input logic [7:0] expD);
    checks++;
    if (dataOe !== expOe || (expOe && dataOut !== expD)) begin
      errors++;
      $display("FAIL %s: oe=%b data=%h expected oe=%b data=%h", tag, dataOe, dataOut, expOe, expD);
    end
  endtask

  task automatic checkBit(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic c, input logic o, input logic v, input logic h,
                      input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ceN = c; oeN = o; vppOn = v; idHv = h; addr = a; dataIn = d;
    @(posedge clk);
    #1;
  endtask

  task automatic waitIdle(output int n);
    n = 0;
    while (eraseBusy && n < DEPTH + 20) begin
      @(posedge clk);
      #1;
      n++;
    end
  endtask

  initial begin
    #(5 * 150000);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1;
    checkBit("R1 busy in reset", eraseBusy, 1'b1);
    check("R1 no drive in reset", 1'b0, 8'h00);
    @(negedge clk);
    rstN = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0, '0, 8'h00);
    check("R10 no drive while sweeping", 1'b0, 8'h00);
    waitIdle(n);
    checkBit("R1 sweep ends", eraseBusy, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      logic [47:0] r;
      r = TBL[i];
      step(r[39], r[38], r[37], r[36], r[20+ADDR_W-1:20], r[19:12]);
      check($sformatf("R%0d row %0d", r[47:40], i), r[11], r[10:3]);
    end

    // R9: odd parity of both identify bytes
    step(1'b0, 1'b0, 1'b0, 1'b1, ADDR_W'(0), 8'h00);
    checkBit("R9 maker parity", ^dataOut, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1, ADDR_W'(1), 8'h00);
    checkBit("R9 device parity", ^dataOut, 1'b1);

    // R11: erase request, count busy cycles, program attempt blocked (R10)
    step(1'b1, 1'b1, 1'b0, 1'b0, ADDR_W'(9), 8'h00);
    @(negedge clk);
    eraseReq = 1'b1;
    @(posedge clk);
    #1;
    eraseReq = 1'b0;
    checkBit("R11 busy raised", eraseBusy, 1'b1);
    n = 0;
    while (eraseBusy && n < DEPTH + 20) begin
      if (n == 10) begin
        @(negedge clk);
        ceN = 1'b0; vppOn = 1'b1; addr = ADDR_W'(2047); dataIn = 8'h00;
      end
      if (n == 11) check("R10 no drive during erase", 1'b0, 8'h00);
      @(posedge clk);
      #1;
      n++;
    end
    checks++;
    if (n != DEPTH) begin
      errors++;
      $display("FAIL R11 busy length: actual %0d expected %0d", n, DEPTH);
    end
    step(1'b0, 1'b0, 1'b0, 1'b0, ADDR_W'(5), 8'h00);
    check("R11 erased addr 5", 1'b1, 8'hFF);
    step(1'b0, 1'b0, 1'b0, 1'b0, ADDR_W'(2047), 8'h00);
    check("R10 program during erase ignored", 1'b1, 8'hFF);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule